// File: doc/BRIEF.md
# Programmable Edge and Level Interrupt Bank

This block watches a group of external input lines (eight by default) and raises interrupts when a programmed event happens on one of them. Each line is first brought into the block's clock domain. The block then compares it against the sample taken one cycle earlier. A per-line trigger setting picks the event that counts:

- a rising edge,
- a falling edge,
- either edge,
- a high level,
- a low level.

Pending events collect in a status vector. Software reads and clears that vector through a small word-addressed register port. The enabled part of the status is OR-reduced onto one interrupt line.

Three configuration vectors select the trigger, one bit per line in each:

- A level-select vector chooses level or edge detection.
- An any-edge vector makes edge detection fire on both transitions.
- A polarity vector picks rising/high or falling/low.

An edge event stays pending until software clears it. A level event tracks the input, so it comes back right after a clear if the line is still in its active state. Software can also read the synchronized input levels directly.

Top module: `ieb_bank`

## Requirements
- R1: After reset every readable register returns zero and `irq_o` is low.
- R2: The input-level register at offset 0x1C shows in bit i the value of `ext_in[i]` two clock edges after it was applied.
- R3: In edge mode (level-select bit 0, any-edge bit 0), a polarity bit of 1 makes a synchronized 0-to-1 transition set that line's pending bit in the raw status register (offset 0x04). The bit stays set after the input falls, until it is cleared.
- R4: In edge mode with any-edge 0 and polarity 0, a synchronized 1-to-0 transition sets the pending bit and a 0-to-1 transition does not.
- R5: In edge mode with any-edge bit 1, either transition sets the pending bit whatever the polarity bit holds.
- R6: With level-select bit 1, the pending bit is 1 while the synchronized input equals the polarity bit (1 = high, 0 = low), and 0 otherwise.
- R7: Writing a 1 to bit i of the clear register at offset 0x0C clears pending bit i for one edge. A 0 bit has no effect. An active level sets the bit again on the following edge. An edge event that arrives in the same cycle as its clear is kept.
- R8: The masked status register (offset 0x08) equals raw status AND the enable register (offset 0x00). `irq_o` is high exactly when any masked bit is 1.
- R9: The enable (0x00), level-select (0x10), any-edge (0x14) and polarity (0x18) registers read back the low NCH bits last written. The clear register and unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling and register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_in | input | NCH | Raw external lines, asynchronous to clk |
| bus_addr | input | AW | Byte offset of the register being read or written |
| bus_wr | input | 1 | Write strobe, taken on the rising clock edge |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Combined interrupt: OR of enabled pending bits |

## Verification
The hardest case to reach from the ports is a clear written in exactly the cycle when a new edge reaches the detector. It is reached only if the input toggle lands two edges before the clear write. A second hard case is a level line seen at its one-cycle low just after a clear. The stimulus keeps a cycle-accurate model of the two-stage sampling path. Random input toggles are mixed with random clear writes at a high rate, so both coincidences occur many times. Directed sequences place a clear right after the level becomes active, then watch `irq_o` drop for one cycle and return.

// File: rtl/ieb_pkg.sv
package ieb_pkg;
   // Register byte offsets, decoded by software
   localparam int unsigned OFS_ENA  = 32'h00;
   localparam int unsigned OFS_RAW  = 32'h04;
   localparam int unsigned OFS_MSK  = 32'h08;
   localparam int unsigned OFS_CLR  = 32'h0C;
   localparam int unsigned OFS_LVL  = 32'h10;
   localparam int unsigned OFS_ANY  = 32'h14;
   localparam int unsigned OFS_POL  = 32'h18;
   localparam int unsigned OFS_PIN  = 32'h1C;

   // Per-line trigger selection
   typedef struct packed {
      logic lvl;   // 1: level detection, 0: edge detection
      logic any;   // edge mode: fire on both transitions
      logic pol;   // 1: rising/high, 0: falling/low
   } trig_t;
endpackage

// File: rtl/ieb_sync.sv
module ieb_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o,
   output logic [W-1:0] q_prev_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ieb_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];
   logic [W-1:0] prev_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            chain[s] <= '0;
         else if (s == 0)
            chain[s] <= d_i;
         else
            chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= chain[STAGES-1];
   end

   assign q_o      = chain[STAGES-1];
   assign q_prev_o = prev_q;
endmodule

// File: rtl/ieb_chan.sv
module ieb_chan
   import ieb_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  cur_i,
   input  logic  prev_i,
   input  trig_t cfg_i,
   input  logic  clr_i,
   output logic  pend_o
);
   logic edge_hit, lvl_hit, pend_q;

   always_comb begin
      if (cfg_i.any)      edge_hit = cur_i ^ prev_i;
      else if (cfg_i.pol) edge_hit = cur_i & ~prev_i;
      else                edge_hit = ~cur_i & prev_i;
      lvl_hit = ~(cur_i ^ cfg_i.pol);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pend_q <= 1'b0;
      else if (cfg_i.lvl) pend_q <= lvl_hit & ~clr_i;
      else                pend_q <= edge_hit | (pend_q & ~clr_i);
   end

   assign pend_o = pend_q;

   AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_i.lvl && pend_q && !clr_i) |=> pend_q); // R3
   AST_LEVEL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_i.lvl && clr_i) |=> !pend_q); // R7
   AST_NO_SPURIOUS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_i.lvl && !pend_q && (cur_i == prev_i)) |=> !pend_q); // R5
endmodule

// File: rtl/ieb_regs.sv
module ieb_regs
   import ieb_pkg::*;
#(
   parameter int unsigned NCH = 8,
   parameter int unsigned AW  = 5,
   parameter int unsigned DW  = 32
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [AW-1:0]  addr_i,
   input  logic           wr_i,
   input  logic [DW-1:0]  wdata_i,
   input  logic [NCH-1:0] pend_i,
   input  logic [NCH-1:0] pin_i,
   output logic [NCH-1:0] ena_o,
   output trig_t          cfg_o [NCH],
   output logic [NCH-1:0] clr_o,
   output logic [DW-1:0]  rdata_o
);
   logic [NCH-1:0] ena_q, lvl_q, any_q, pol_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ena_q <= '0;
         lvl_q <= '0;
         any_q <= '0;
         pol_q <= '0;
      end else if (wr_i) begin
         if (addr_i == AW'(OFS_ENA)) ena_q <= wdata_i[NCH-1:0];
         if (addr_i == AW'(OFS_LVL)) lvl_q <= wdata_i[NCH-1:0];
         if (addr_i == AW'(OFS_ANY)) any_q <= wdata_i[NCH-1:0];
         if (addr_i == AW'(OFS_POL)) pol_q <= wdata_i[NCH-1:0];
      end
   end

   assign clr_o = (wr_i && addr_i == AW'(OFS_CLR)) ? wdata_i[NCH-1:0] : '0;
   assign ena_o = ena_q;

   for (genvar i = 0; i < NCH; i++) begin : g_cfg
      assign cfg_o[i] = '{lvl: lvl_q[i], any: any_q[i], pol: pol_q[i]};
   end

   always_comb begin
      rdata_o = '0;
      if      (addr_i == AW'(OFS_ENA)) rdata_o[NCH-1:0] = ena_q;
      else if (addr_i == AW'(OFS_RAW)) rdata_o[NCH-1:0] = pend_i;
      else if (addr_i == AW'(OFS_MSK)) rdata_o[NCH-1:0] = pend_i & ena_q;
      else if (addr_i == AW'(OFS_LVL)) rdata_o[NCH-1:0] = lvl_q;
      else if (addr_i == AW'(OFS_ANY)) rdata_o[NCH-1:0] = any_q;
      else if (addr_i == AW'(OFS_POL)) rdata_o[NCH-1:0] = pol_q;
      else if (addr_i == AW'(OFS_PIN)) rdata_o[NCH-1:0] = pin_i;
   end
endmodule

// File: rtl/ieb_bank.sv
module ieb_bank
   import ieb_pkg::*;
#(
   parameter int unsigned NCH         = 8,
   parameter int unsigned AW          = 5,
   parameter int unsigned DW          = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] ext_in,
   input  logic [AW-1:0]  bus_addr,
   input  logic           bus_wr,
   input  logic [DW-1:0]  bus_wdata,
   output logic [DW-1:0]  bus_rdata,
   output logic           irq_o
);
   localparam int unsigned MAX_OFS = OFS_PIN;

   if (NCH < 1 || NCH > DW) begin : g_bad_nch
      $error("ieb_bank: NCH must lie in 1..DW");
   end
   if ((1 << AW) <= MAX_OFS) begin : g_bad_aw
      $error("ieb_bank: AW too narrow for the register map");
   end

   logic [NCH-1:0] pin_s, pin_prev, pend, ena, clr;
   trig_t          cfg [NCH];

   ieb_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .d_i      (ext_in),
      .q_o      (pin_s),
      .q_prev_o (pin_prev)
   );

   ieb_regs #(.NCH(NCH), .AW(AW), .DW(DW)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr_i  (bus_addr),
      .wr_i    (bus_wr),
      .wdata_i (bus_wdata),
      .pend_i  (pend),
      .pin_i   (pin_s),
      .ena_o   (ena),
      .cfg_o   (cfg),
      .clr_o   (clr),
      .rdata_o (bus_rdata)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_chan
      ieb_chan u_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .cur_i  (pin_s[i]),
         .prev_i (pin_prev[i]),
         .cfg_i  (cfg[i]),
         .clr_i  (clr[i]),
         .pend_o (pend[i])
      );
   end

   assign irq_o = |(pend & ena);

   AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (ena != '0)); // R8
   AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (pend != '0)); // R8
endmodule

// File: tb/tb_ieb_bank.sv
`timescale 1ns/1ps
module tb_ieb_bank;
   localparam int NCH = 8;
   localparam int AW  = 5;
   localparam int DW  = 32;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NCH-1:0] ext_in = '0;
   logic [AW-1:0]  bus_addr = '0;
   logic           bus_wr = 1'b0;
   logic [DW-1:0]  bus_wdata = '0;
   logic [DW-1:0]  bus_rdata;
   logic           irq_o;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   // Bench model state (post-edge values)
   logic [7:0] m_s1, m_s2, m_prev, m_pend, m_ena, m_lvl, m_any, m_pol;

   always #2 clk = ~clk;

   ieb_bank #(.NCH(NCH), .AW(AW), .DW(DW)) dut (
      .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
   );

   function automatic logic [31:0] model_read(input logic [4:0] a);
      case (a)
         5'h00: return {24'h0, m_ena};
         5'h04: return {24'h0, m_pend};
         5'h08: return {24'h0, m_pend & m_ena};
         5'h10: return {24'h0, m_lvl};
         5'h14: return {24'h0, m_any};
         5'h18: return {24'h0, m_pol};
         5'h1C: return {24'h0, m_s2};
         default: return 32'h0;
      endcase
   endfunction

   function automatic string tag_for(input logic [4:0] a);
      case (a)
         5'h00, 5'h10, 5'h14, 5'h18, 5'h0C: return "R9";
         5'h04: return "R3";
         5'h08: return "R8";
         5'h1C: return "R2";
         default: return "R9";
      endcase
   endfunction

   task automatic model_step(input logic [7:0] din, input bit wr,
                             input logic [4:0] a, input logic [31:0] wd);
      logic [7:0] clr, nxt;
      clr = (wr && a == 5'h0C) ? wd[7:0] : 8'h0;
      for (int i = 0; i < 8; i++) begin
         logic eh;
         if (m_any[i])      eh = m_s2[i] ^ m_prev[i];
         else if (m_pol[i]) eh = m_s2[i] & ~m_prev[i];
         else               eh = ~m_s2[i] & m_prev[i];
         if (m_lvl[i]) nxt[i] = (m_s2[i] == m_pol[i]) && !clr[i];
         else          nxt[i] = eh | (m_pend[i] & ~clr[i]);
      end
      m_pend = nxt;
      if (wr) begin
         if (a == 5'h00) m_ena = wd[7:0];
         if (a == 5'h10) m_lvl = wd[7:0];
         if (a == 5'h14) m_any = wd[7:0];
         if (a == 5'h18) m_pol = wd[7:0];
      end
      m_prev = m_s2;
      m_s2   = m_s1;
      m_s1   = din;
   endtask

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // One clock: drive at negedge, model the edge, compare at next negedge
   task automatic step(input string tag, input logic [7:0] din, input bit wr,
                       input logic [4:0] a, input logic [31:0] wd);
      ext_in = din; bus_wr = wr; bus_addr = a; bus_wdata = wd;
      model_step(din, wr, a, wd);
      @(posedge clk);
      @(negedge clk);
      check(tag, "rdata", bus_rdata, model_read(a));
      check((tag == "R7") ? "R7" : "R8", "irq", {31'h0, irq_o},
            {31'h0, |(m_pend & m_ena)});
   endtask

   task automatic wr_reg(input string tag, input logic [4:0] a, input logic [7:0] v);
      step(tag, ext_in, 1'b1, a, {24'h0, v});
   endtask

   task automatic idle(input string tag, input logic [7:0] din,
                       input logic [4:0] a, input int n);
      for (int k = 0; k < n; k++) step(tag, din, 1'b0, a, 32'h0);
   endtask

   initial begin
      #400000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [4:0] addrs [8];
      addrs = '{5'h00, 5'h04, 5'h08, 5'h0C, 5'h10, 5'h14, 5'h18, 5'h1C};
      void'($urandom(32'h5EED_1234));
      {m_s1, m_s2, m_prev, m_pend, m_ena, m_lvl, m_any, m_pol} = '0;
      repeat (3) @(negedge clk);
      // R1: reset state on all offsets
      for (int k = 0; k < 8; k++) begin
         bus_addr = addrs[k];
         #0.5;
         check("R1", "reset rdata", bus_rdata, 32'h0);
      end
      check("R1", "reset irq", {31'h0, irq_o}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R9: readback and unmapped offsets
      wr_reg("R9", 5'h10, 8'h3C); idle("R9", 8'h00, 5'h10, 1);
      wr_reg("R9", 5'h14, 8'hA1); idle("R9", 8'h00, 5'h14, 1);
      wr_reg("R9", 5'h18, 8'h5A); idle("R9", 8'h00, 5'h18, 1);
      idle("R9", 8'h00, 5'h0C, 1);
      idle("R9", 8'h00, 5'h1E, 1);

      // R2: input level register after two edges
      idle("R2", 8'hA5, 5'h1C, 3);
      idle("R2", 8'h3C, 5'h1C, 3);

      // R3: rising edge, sticky
      wr_reg("R3", 5'h10, 8'h00); wr_reg("R3", 5'h14, 8'h00);
      wr_reg("R3", 5'h18, 8'hFF); idle("R3", 8'h00, 5'h04, 4);
      wr_reg("R3", 5'h0C, 8'hFF); wr_reg("R3", 5'h00, 8'hFF);
      idle("R3", 8'h01, 5'h04, 4);
      idle("R3", 8'h00, 5'h04, 4);
      check("R3", "sticky bit0", {31'h0, bus_rdata[0]}, 32'h1);

      // R4: falling edge only
      wr_reg("R4", 5'h18, 8'h00); wr_reg("R4", 5'h0C, 8'hFF);
      idle("R4", 8'h02, 5'h04, 4);
      check("R4", "no rise trig", {31'h0, bus_rdata[1]}, 32'h0);
      idle("R4", 8'h00, 5'h04, 4);
      check("R4", "fall trig", {31'h0, bus_rdata[1]}, 32'h1);

      // R5: both edges regardless of polarity
      wr_reg("R5", 5'h14, 8'hFF); wr_reg("R5", 5'h0C, 8'hFF);
      idle("R5", 8'h04, 5'h04, 4);
      check("R5", "any rise", {31'h0, bus_rdata[2]}, 32'h1);
      wr_reg("R5", 5'h0C, 8'h04); idle("R5", 8'h00, 5'h04, 4);

      // R6: levels follow input
      wr_reg("R6", 5'h14, 8'h00); wr_reg("R6", 5'h18, 8'h0F);
      wr_reg("R6", 5'h10, 8'hFF);
      idle("R6", 8'h33, 5'h04, 4);
      idle("R6", 8'hCC, 5'h04, 4);

      // R7: level re-asserts after clear; zero bits ignored
      wr_reg("R7", 5'h0C, 8'h00);
      wr_reg("R7", 5'h0C, 8'hFF);
      idle("R7", 8'hCC, 5'h04, 3);
      // R7: edge arriving together with clear is kept
      wr_reg("R7", 5'h10, 8'h00); wr_reg("R7", 5'h18, 8'hFF);
      wr_reg("R7", 5'h0C, 8'hFF);
      step("R7", 8'hCD, 1'b0, 5'h04, 32'h0);
      step("R7", 8'hCD, 1'b0, 5'h04, 32'h0);
      step("R7", 8'hCD, 1'b1, 5'h0C, 32'h01);
      idle("R7", 8'hCD, 5'h04, 2);
      check("R7", "edge kept", {31'h0, bus_rdata[0]}, 32'h1);

      // R8: masking
      wr_reg("R8", 5'h00, 8'h0A); idle("R8", 8'hCD, 5'h08, 2);

      // Random phase
      for (int n = 0; n < 4000; n++) begin
         logic [4:0] a;
         bit w;
         logic [7:0] d;
         a = addrs[$urandom_range(0, 7)];
         w = ($urandom_range(0, 3) == 0) && (a != 5'h04) && (a != 5'h08) && (a != 5'h1C);
         d = ($urandom_range(0, 1) == 0) ? ext_in : ext_in ^ 8'($urandom_range(0, 255));
         step(tag_for(a), d, w, a, {24'h0, 8'($urandom_range(0, 255))});
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule